// File: doc/BRIEF.md
# Ranked Shared-Tagged Owner Tracker

This block keeps the coherence bookkeeping for a single line held by several caches that use dirty cache-to-cache transfer. At any moment at most one cache owns the dirty data. That owner is either Modified, which means it holds the only copy, or Tagged, which means other copies exist. Other holders are either plain Shared or ranked backups that can inherit dirty ownership. The ranks run from 1 up to a parameterised limit, and only the rank-1 backup is able to take over.

The surrounding coherence logic reports one event per cycle. Each event carries a cache index and is one of three kinds: a read miss, an eviction of a copy, or a write that invalidates all other copies. The tracker updates the state and rank of every cache on the next clock edge. In the same cycle as an eviction, it also reports whether the evicted dirty data must be written back to memory or whether the write-back is suppressed because a backup takes over. When a backup takes over, it reports which cache that is. Moving the data and holding the data arrays are left to other logic.

Top module: `rank_owner_tracker`

## Requirements
- R1: After reset every cache reads Invalid with rank 0. State codes on `state_o` are 0 Invalid, 1 Shared, 2 Modified, 3 Tagged and 4 Backup. Cache i occupies bits [3i+2:3i], and its rank occupies the matching RW-bit slice of `rank_o`.
- R2: Take a read miss (kind 1) from an Invalid cache while a Modified or Tagged copy exists. The requester becomes Tagged and the previous owner becomes Backup with rank 1.
- R3: On such a read miss, every existing Backup moves up one rank. A Backup already at rank NRANK becomes Shared with rank 0.
- R4: A read miss with no Modified or Tagged copy present makes the requester Shared and changes no other cache. A read miss issued by a cache that already holds a copy changes nothing.
- R5: Take an eviction (kind 2) of the Tagged cache while a rank-1 Backup exists. `wb_block_o` is high in that cycle and `heir_idx_o` names the rank-1 holder. The rank-1 holder then becomes Tagged, every other Backup drops one rank, and the evicted cache becomes Invalid.
- R6: Take an eviction of the Tagged cache with no rank-1 Backup present. `wb_go_o` is high in that cycle, and every remaining Backup becomes Shared. The ranks left behind by a broken chain never grant ownership.
- R7: Evicting a Backup of rank k makes only that cache Invalid. Every other rank keeps its value, so the Backups above k keep their labels.
- R8: Evicting a Modified cache raises `wb_go_o`. Evicting a Shared or Invalid cache raises neither write-back output, and that cache becomes or stays Invalid.
- R9: A write with invalidate (kind 3) makes the writer Modified and every other cache Invalid, with all ranks cleared.
- R10: `wb_go_o` and `wb_block_o` are never high together, and both are low in any cycle with no valid eviction.
- R11: While `ev_valid_i` is low, no state or rank changes.
- R12: At no point does more than one cache hold the Modified or Tagged state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid_i | input | 1 | Event present this cycle |
| ev_kind_i | input | 2 | 1 read miss, 2 eviction, 3 write with invalidate, 0 no-op |
| ev_idx_i | input | IW | Cache the event refers to |
| state_o | output | 3*N | Per-cache state code |
| rank_o | output | RW*N | Per-cache backup rank, 0 when not a Backup |
| wb_go_o | output | 1 | Evicted dirty data must go to memory |
| wb_block_o | output | 1 | Write-back suppressed, rank-1 backup takes over |
| heir_idx_o | output | IW | Index of the rank-1 backup |

## Verification
A wrong rank does not show up at once. It surfaces at the next eviction of the Tagged cache, where the wrong cache inherits ownership or the write-back decision flips. It can also surface at the next read miss, where a backup that should have fallen to Shared stays ranked. For this reason the bench compares every state and rank after each event against a reference model, instead of waiting for the write-back outputs to go wrong. Random event streams are mixed with a directed chain that breaks at rank 2 and then loses the owner twice, which covers both takeover and loss of ownership.

// File: rtl/sttrk_pkg.sv
package sttrk_pkg;

    typedef enum logic [2:0] {
        ST_INV = 3'd0,
        ST_SHR = 3'd1,
        ST_MOD = 3'd2,
        ST_TAG = 3'd3,
        ST_BKP = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_RDM   = 2'd1,
        EV_EVICT = 2'd2,
        EV_WRINV = 2'd3
    } ev_kind_e;

endpackage

// File: rtl/sttrk_scan.sv
module sttrk_scan
    import sttrk_pkg::*;
#(
    parameter int N  = 8,
    parameter int RW = 2,
    parameter int IW = 3
) (
    input  logic [N-1:0][2:0]    st_i,
    input  logic [N-1:0][RW-1:0] rk_i,
    output logic                 has_owner_o,
    output logic                 has_st1_o,
    output logic [IW-1:0]        st1_idx_o
);

    logic [N-1:0] own_v;
    logic [N-1:0] st1_v;

    // flag dirty owners and the rank-1 backup per cache
    for (genvar i = 0; i < N; i++) begin : g_flag
        assign own_v[i] = (st_i[i] == ST_MOD) || (st_i[i] == ST_TAG);
        assign st1_v[i] = (st_i[i] == ST_BKP) && (rk_i[i] == RW'(1));
    end

    assign has_owner_o = |own_v;
    assign has_st1_o   = |st1_v;

    // lowest index wins; at most one is set when the state is legal
    always_comb begin
        st1_idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (st1_v[i]) begin
                st1_idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/sttrk_slot.sv
module sttrk_slot
    import sttrk_pkg::*;
#(
    parameter int NRANK = 3,
    parameter int RW    = 2
) (
    input  logic          ev_act_i,
    input  logic [1:0]    kind_i,
    input  logic          is_self_i,
    input  logic          req_free_i,
    input  logic          has_owner_i,
    input  logic          evict_tag_i,
    input  logic          has_st1_i,
    input  logic [2:0]    st_i,
    input  logic [RW-1:0] rk_i,
    output logic [2:0]    st_d,
    output logic [RW-1:0] rk_d
);

    localparam logic [RW-1:0] RMAX = RW'(NRANK);
    localparam logic [RW-1:0] RONE = RW'(1);

    always_comb begin
        st_d = st_i;
        rk_d = rk_i;
        if (ev_act_i) begin
            case (kind_i)
                EV_RDM: begin
                    if (req_free_i) begin
                        if (is_self_i) begin
                            st_d = has_owner_i ? ST_TAG : ST_SHR;
                            rk_d = '0;
                        end else if (has_owner_i) begin
                            if (st_i == ST_MOD || st_i == ST_TAG) begin
                                st_d = ST_BKP;
                                rk_d = RONE;
                            end else if (st_i == ST_BKP) begin
                                if (rk_i == RMAX) begin
                                    st_d = ST_SHR;
                                    rk_d = '0;
                                end else begin
                                    rk_d = rk_i + 1'b1;
                                end
                            end
                        end
                    end
                end
                EV_EVICT: begin
                    if (is_self_i) begin
                        st_d = ST_INV;
                        rk_d = '0;
                    end else if (evict_tag_i && st_i == ST_BKP) begin
                        if (has_st1_i) begin
                            if (rk_i == RONE) begin
                                st_d = ST_TAG;
                                rk_d = '0;
                            end else begin
                                rk_d = rk_i - 1'b1;
                            end
                        end else begin
                            st_d = ST_SHR;
                            rk_d = '0;
                        end
                    end
                end
                EV_WRINV: begin
                    st_d = is_self_i ? ST_MOD : ST_INV;
                    rk_d = '0;
                end
                default: begin
                    st_d = st_i;
                    rk_d = rk_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/rank_owner_tracker.sv
module rank_owner_tracker
    import sttrk_pkg::*;
#(
    parameter int N     = 8,
    parameter int NRANK = 3,
    localparam int IW   = (N > 1) ? $clog2(N) : 1,
    localparam int RW   = $clog2(NRANK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid_i,
    input  logic [1:0]        ev_kind_i,
    input  logic [IW-1:0]     ev_idx_i,
    output logic [3*N-1:0]    state_o,
    output logic [RW*N-1:0]   rank_o,
    output logic              wb_go_o,
    output logic              wb_block_o,
    output logic [IW-1:0]     heir_idx_o
);

    localparam logic [IW:0] NCNT = (IW + 1)'(N);

    typedef struct packed {
        logic [N-1:0][2:0]    st;
        logic [N-1:0][RW-1:0] rk;
    } trk_s;

    trk_s cur_q, nxt_d;

    logic                 ev_act;
    logic [2:0]           ev_st;
    logic                 has_owner;
    logic                 has_st1;
    logic [IW-1:0]        st1_idx;
    logic                 is_evict;
    logic [N-1:0][2:0]    slot_st;
    logic [N-1:0][RW-1:0] slot_rk;

    assign ev_act   = ev_valid_i && ({1'b0, ev_idx_i} < NCNT);
    assign ev_st    = cur_q.st[ev_idx_i];
    assign is_evict = ev_act && (ev_kind_i == EV_EVICT);

    sttrk_scan #(
        .N  (N),
        .RW (RW),
        .IW (IW)
    ) u_scan (
        .st_i        (cur_q.st),
        .rk_i        (cur_q.rk),
        .has_owner_o (has_owner),
        .has_st1_o   (has_st1),
        .st1_idx_o   (st1_idx)
    );

    for (genvar i = 0; i < N; i++) begin : g_slot
        sttrk_slot #(
            .NRANK (NRANK),
            .RW    (RW)
        ) u_slot (
            .ev_act_i    (ev_act),
            .kind_i      (ev_kind_i),
            .is_self_i   (ev_idx_i == IW'(i)),
            .req_free_i  (ev_st == ST_INV),
            .has_owner_i (has_owner),
            .evict_tag_i (ev_st == ST_TAG),
            .has_st1_i   (has_st1),
            .st_i        (cur_q.st[i]),
            .rk_i        (cur_q.rk[i]),
            .st_d        (slot_st[i]),
            .rk_d        (slot_rk[i])
        );
    end

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.st = slot_st;
        nxt_d.rk = slot_rk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // eviction verdicts are combinational, valid in the event cycle
    assign wb_go_o    = is_evict && ((ev_st == ST_MOD) || (ev_st == ST_TAG && !has_st1));
    assign wb_block_o = is_evict && (ev_st == ST_TAG) && has_st1;
    assign heir_idx_o = st1_idx;

    for (genvar i = 0; i < N; i++) begin : g_out
        assign state_o[3*i +: 3]   = cur_q.st[i];
        assign rank_o[RW*i +: RW]  = cur_q.rk[i];
    end

endmodule

// File: rtl/sttrk_chk.sv
module sttrk_chk
    import sttrk_pkg::*;
#(
    parameter int N     = 8,
    parameter int NRANK = 3,
    parameter int IW    = 3,
    parameter int RW    = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ev_valid_i,
    input logic [1:0]      ev_kind_i,
    input logic [IW-1:0]   ev_idx_i,
    input logic [3*N-1:0]  state_o,
    input logic [RW*N-1:0] rank_o,
    input logic            wb_go_o,
    input logic            wb_block_o,
    input logic [IW-1:0]   heir_idx_o
);

    logic [2:0]    st_a [N];
    logic [N-1:0]  own_v, tag_v, bkp_v, val_v, rk_bad;
    logic [IW-1:0] heir_q;
    logic          wr_ev;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            st_a[i]   = state_o[3*i +: 3];
            own_v[i]  = (st_a[i] == ST_MOD) || (st_a[i] == ST_TAG);
            tag_v[i]  = (st_a[i] == ST_TAG);
            bkp_v[i]  = (st_a[i] == ST_BKP);
            val_v[i]  = (st_a[i] != ST_INV);
            rk_bad[i] = bkp_v[i]
                ? ((rank_o[RW*i +: RW] == '0) || (int'(rank_o[RW*i +: RW]) > NRANK))
                : (rank_o[RW*i +: RW] != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) heir_q <= '0;
        else        heir_q <= heir_idx_o;
    end

    assign wr_ev = ev_valid_i && (ev_kind_i == EV_WRINV) && (int'(ev_idx_i) < N);

    assert_one_owner_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(own_v) <= 1);

    assert_backup_needs_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|bkp_v) |-> (|tag_v));

    assert_rank_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rk_bad == '0);

    assert_wb_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_go_o && wb_block_o));

    assert_wb_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid_i |-> (!wb_go_o && !wb_block_o));

    assert_heir_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_block_o |=> (st_a[heir_q] == ST_TAG));

    assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ev |=> ($countones(val_v) == 1 && $countones(own_v) == 1));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid_i |=> ($stable(state_o) && $stable(rank_o)));

endmodule

bind rank_owner_tracker sttrk_chk #(
    .N     (N),
    .NRANK (NRANK),
    .IW    (IW),
    .RW    (RW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid_i (ev_valid_i),
    .ev_kind_i  (ev_kind_i),
    .ev_idx_i   (ev_idx_i),
    .state_o    (state_o),
    .rank_o     (rank_o),
    .wb_go_o    (wb_go_o),
    .wb_block_o (wb_block_o),
    .heir_idx_o (heir_idx_o)
);

// File: tb/tb_rank_owner_tracker.sv
module tb_rank_owner_tracker;

    localparam int N     = 8;
    localparam int NRANK = 3;
    localparam int IW    = 3;
    localparam int RW    = 2;

    localparam int S_INV = 0, S_SHR = 1, S_MOD = 2, S_TAG = 3, S_BKP = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ev_valid_i = 1'b0;
    logic [1:0]      ev_kind_i = 2'd0;
    logic [IW-1:0]   ev_idx_i = '0;
    logic [3*N-1:0]  state_o;
    logic [RW*N-1:0] rank_o;
    logic            wb_go_o, wb_block_o;
    logic [IW-1:0]   heir_idx_o;

    int n_tests = 0;
    int n_fail  = 0;
    int m_st [N];
    int m_rk [N];
    bit done = 1'b0;

    always #4 clk = ~clk;

    rank_owner_tracker #(.N(N), .NRANK(NRANK)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid_i (ev_valid_i),
        .ev_kind_i  (ev_kind_i),
        .ev_idx_i   (ev_idx_i),
        .state_o    (state_o),
        .rank_o     (rank_o),
        .wb_go_o    (wb_go_o),
        .wb_block_o (wb_block_o),
        .heir_idx_o (heir_idx_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [3*N-1:0] exp_state();
        logic [3*N-1:0] v;
        for (int i = 0; i < N; i++) v[3*i +: 3] = 3'(m_st[i]);
        return v;
    endfunction

    function automatic logic [RW*N-1:0] exp_rank();
        logic [RW*N-1:0] v;
        for (int i = 0; i < N; i++) v[RW*i +: RW] = RW'(m_rk[i]);
        return v;
    endfunction

    function automatic int find_owner();
        for (int i = 0; i < N; i++) if (m_st[i] == S_MOD || m_st[i] == S_TAG) return i;
        return -1;
    endfunction

    function automatic int find_rank1();
        for (int i = 0; i < N; i++) if (m_st[i] == S_BKP && m_rk[i] == 1) return i;
        return -1;
    endfunction

    // one event: drive, check same-cycle verdicts, clock, check states
    task automatic step(input bit v, input int kind, input int idx);
        string tag;
        int    own, h, e;
        bit    eg, eb;
        ev_valid_i = v;
        ev_kind_i  = 2'(kind);
        ev_idx_i   = IW'(idx);
        #1;
        own = find_owner();
        h   = find_rank1();
        e   = m_st[idx];
        eg  = v && kind == 2 && (e == S_MOD || (e == S_TAG && h < 0));
        eb  = v && kind == 2 && e == S_TAG && h >= 0;
        check("R10 wb_go", wb_go_o, eg);
        check("R10 wb_block", wb_block_o, eb);
        if (eb) check("R5 heir", heir_idx_o, h);
        tag = "R11";
        if (v) begin
            case (kind)
                1: begin
                    if (e != S_INV) tag = "R4";
                    else if (own < 0) begin
                        tag = "R4";
                        m_st[idx] = S_SHR;
                    end else begin
                        tag = "R2";
                        for (int j = 0; j < N; j++) begin
                            if (j == idx) begin m_st[j] = S_TAG; m_rk[j] = 0; end
                            else if (j == own) begin m_st[j] = S_BKP; m_rk[j] = 1; end
                            else if (m_st[j] == S_BKP) begin
                                if (m_rk[j] == NRANK) begin
                                    tag = "R3";
                                    m_st[j] = S_SHR; m_rk[j] = 0;
                                end else m_rk[j]++;
                            end
                        end
                    end
                end
                2: begin
                    m_st[idx] = S_INV; m_rk[idx] = 0;
                    if (e == S_TAG) begin
                        tag = (h >= 0) ? "R5" : "R6";
                        for (int j = 0; j < N; j++) begin
                            if (m_st[j] == S_BKP) begin
                                if (h < 0) begin m_st[j] = S_SHR; m_rk[j] = 0; end
                                else if (j == h) begin m_st[j] = S_TAG; m_rk[j] = 0; end
                                else m_rk[j]--;
                            end
                        end
                    end else if (e == S_BKP) tag = "R7";
                    else tag = "R8";
                end
                3: begin
                    tag = "R9";
                    for (int j = 0; j < N; j++) begin
                        m_st[j] = (j == idx) ? S_MOD : S_INV;
                        m_rk[j] = 0;
                    end
                end
                default: tag = "R11";
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " state"}, state_o, exp_state());
        check({tag, " rank"},  rank_o,  exp_rank());
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_st[i] = S_INV; m_rk[i] = 0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", state_o, '0);
        check("R1 reset rank", rank_o, '0);

        // directed: build a chain deeper than NRANK, break it at rank 2
        step(1, 3, 0);                 // R9: cache0 Modified
        step(1, 1, 1);                 // R2
        step(1, 1, 2);
        step(1, 1, 3);
        step(1, 1, 4);                 // R3: cache0 falls to Shared
        check("R3 overflow to shared", state_o[2:0], S_SHR);
        step(1, 1, 4);                 // R4: holder re-reads, ignored
        step(0, 1, 5);                 // R11: invalid event
        step(1, 2, 2);                 // R7: rank 2 gone, cache1 stays rank 3
        check("R7 label kept", rank_o[RW*1 +: RW], 3);
        step(1, 2, 4);                 // R5: cache3 takes over
        check("R5 heir tagged", state_o[3*3 +: 3], S_TAG);
        check("R5 rank drop", rank_o[RW*1 +: RW], 2);
        step(1, 2, 3);                 // R6: no rank-1, write back
        check("R6 demoted", state_o[3*1 +: 3], S_SHR);
        step(1, 2, 1);                 // R8: shared evict
        step(1, 2, 6);                 // R8: invalid evict
        step(1, 1, 6);                 // R4: no owner, Shared
        step(1, 3, 5);
        step(1, 2, 5);                 // R8: Modified evict writes back

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r, k;
            r = int'($urandom_range(99, 0));
            if (r < 45)      k = 1;
            else if (r < 75) k = 2;
            else if (r < 83) k = 3;
            else             k = 0;
            step(k != 0 && r < 95, k == 0 ? int'($urandom_range(3, 0)) : k,
                 int'($urandom_range(N - 1, 0)));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule